// File: doc/BRIEF.md
# Predicated Loop-Counter Execute Controller

This block is the execute stage of a dock's instruction pump. It holds the instruction that is on deck while that instruction runs. It evaluates the instruction's 3-bit predicate against two general flags and the outer loop counter. It owns the outer loop counter (OLC), the inner loop counter (ILC, which can also hold an infinite value) and the three pump flags A, B and C. The queue that feeds it and the data latch it steers are outside the block. The controller receives only the low bits of the data latch, which it loads into a counter, and it drives the strobes that move data.

An instruction is presented on the `od_*` ports with `od_valid` high and is held until `done` pulses. All strobes are combinational from the on-deck fields and the current state. State updates at the clock edge that ends the cycle in which the strobes were seen. A move repeats once for each ready cycle, as many times as ILC requests, and an infinite ILC repeats the move until a torpedo strikes. A torpedo that strikes an interruptible move stops the move, clears OLC and re-arms ILC to one.

The `IS_OUTPUT` parameter selects the dock side. The side changes only where the C flag takes its value from.

Top module: `dock_exec_ctl`

## Requirements
- R1: The predicate `od_pred` selects when an instruction executes:
  - 3'b000: OLC is nonzero and A is 0.
  - 3'b001: OLC is nonzero and A is 1.
  - 3'b010: OLC is nonzero and B is 0.
  - 3'b011: OLC is nonzero and B is 1.
  - 3'b101: OLC is zero.
  - 3'b110: OLC is nonzero.
  - 3'b111: always.
  - 3'b100: never.
- R2: When the predicate fails, `done` is high in that same cycle, and `fire`, `nm_exec` and `torp_take` stay low. No counter or flag changes.
- R3: A move with `od_intr`=1 whose predicate passes while `torp_waiting`=1 does three things in that cycle: it raises `torp_take` and `done`, it does not fire, and it sets OLC to 0 and ILC to finite 1 at the edge. A non-interruptible move, a non-move instruction and an instruction whose predicate fails never take a torpedo.
- R4: `od_kind` 2'd0 is a move. With a finite ILC of N≥1, a move fires once per ready cycle and raises `done` together with its N-th fire. With a finite ILC of 0, a move raises `done` without firing. After every move, ILC is finite 1.
- R5: With ILC infinite, a move fires on every ready cycle and never raises `done` until a torpedo takes it.
- R6: A move fires only in a cycle in which both conditions hold:
  - `dat_succ_empty` and `tok_succ_empty` are both 1.
  - `tok_pred_full` is 1 if `mv_ti` is set, and `dat_pred_full` is 1 if `mv_di` is set.
  
  `fire_ti`, `fire_di`, `fire_dc`, `fire_do` and `fire_to` equal `fire` ANDed with the corresponding move bit.
- R7: C is updated only when a move fires.
  - Input dock (`IS_OUTPUT`=0): C takes `sig_bit` when `mv_ti` or `mv_di` is set.
  - Output dock: C takes `ship_c` when `mv_di` is set, and otherwise takes `sig_bit` when `mv_ti` is set.
  - In every other case C is unchanged.
- R8: A set (`od_kind` 2'd1) with `set_op` 3'd6 loads new A and B values. The new A is the OR of the old-flag terms selected by `next_a`, and the new B is the OR of the terms selected by `next_b`. In both fields bit0 selects A, bit1 not-A, bit2 B, bit3 not-B, bit4 C and bit5 not-C. A field with no bit set gives 0. C is unchanged.
- R9: A set that executes changes OLC as follows:
  - `set_op` 3'd0: OLC loads `set_imm`.
  - `set_op` 3'd1: OLC loads `dl_low`.
  - `set_op` 3'd2: OLC decrements by one.
  - `set_op` 3'd7: OLC and ILC are unchanged.
- R10: A set that executes changes ILC as follows:
  - `set_op` 3'd3: ILC loads `set_imm` as a finite value.
  - `set_op` 3'd4: ILC loads `dl_low` as a finite value.
  - `set_op` 3'd5: ILC becomes infinite (`ilc_inf`=1).
- R11: An OLC decrement at zero leaves OLC at zero. `olc_hit_zero` is high exactly in the cycle whose closing edge takes OLC from nonzero to zero, whatever the cause.
- R12: After reset, OLC is 0, ILC is finite 1, A, B and C are 0, and no strobe is high while `od_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| od_valid | input | 1 | An instruction is on deck |
| od_kind | input | 2 | Instruction kind: 0 move, 1 set, 2 shift, 3 other non-move |
| od_pred | input | 3 | Predicate code |
| od_intr | input | 1 | The move may be interrupted by a torpedo |
| mv_ti | input | 1 | The move takes a token input |
| mv_di | input | 1 | The move takes a data input |
| mv_dc | input | 1 | The move captures into the data latch |
| mv_do | input | 1 | The move emits a data output |
| mv_to | input | 1 | The move emits a token output |
| set_op | input | 3 | Operation selector for a set |
| set_imm | input | IMM_W | Immediate operand of a set |
| dl_low | input | DL_W | Low bits of the data latch |
| next_a | input | 6 | Term select for the new A |
| next_b | input | 6 | Term select for the new B |
| torp_waiting | input | 1 | A torpedo is waiting |
| tok_pred_full | input | 1 | Token source is full |
| dat_pred_full | input | 1 | Data source is full |
| dat_succ_empty | input | 1 | Data destination is empty |
| tok_succ_empty | input | 1 | Token destination is empty |
| sig_bit | input | 1 | Signal bit of the arriving packet |
| ship_c | input | 1 | Control value from the ship |
| done | output | 1 | The on-deck instruction retires this cycle |
| nm_exec | output | 1 | A non-move instruction executes this cycle |
| fire | output | 1 | A move executes once this cycle |
| fire_ti | output | 1 | Drain the token source |
| fire_di | output | 1 | Drain the data source |
| fire_dc | output | 1 | Pulse the data latch |
| fire_do | output | 1 | Fill the data destination |
| fire_to | output | 1 | Fill the token destination |
| torp_take | output | 1 | The waiting torpedo is consumed |
| olc_hit_zero | output | 1 | OLC goes from nonzero to zero at the coming edge |
| olc_val | output | OLC_W | Outer loop counter |
| ilc_val | output | ILC_W | Inner loop counter, finite part |
| ilc_inf | output | 1 | Inner loop counter holds the infinite value |
| flag_a | output | 1 | Flag A |
| flag_b | output | 1 | Flag B |
| flag_c | output | 1 | Flag C |

## Verification
A wrong OLC shows on the very next instruction whose predicate tests OLC: `done` rises without `nm_exec` or `fire`, or the reverse. A wrong ILC or infinite bit shows as an extra fire or a missing fire, or as `done` arriving a cycle early or late on the next move. In the case of an infinite value the move never retires, so the ILC fault shows up within cycles of that move coming on deck. A wrong A, B or C shows one instruction later, either through a predicate outcome or through the flag ports.

// File: rtl/dxc_pkg.sv
package dxc_pkg;

  typedef enum logic [1:0] {
    K_MOVE  = 2'd0,
    K_SET   = 2'd1,
    K_SHIFT = 2'd2,
    K_PLAIN = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_OLC_IMM = 3'd0,
    S_OLC_DL  = 3'd1,
    S_OLC_DEC = 3'd2,
    S_ILC_IMM = 3'd3,
    S_ILC_DL  = 3'd4,
    S_ILC_INF = 3'd5,
    S_FLAGS   = 3'd6,
    S_NONE    = 3'd7
  } setop_e;

  localparam int SEL_W = 6;

  // Predicate evaluation: flag tests are qualified by a nonzero outer count.
  function automatic logic pred_ok(input logic [2:0] code, input logic olc_nz,
                                   input logic a, input logic b);
    logic r;
    case (code)
      3'b000:  r = olc_nz & ~a;
      3'b001:  r = olc_nz &  a;
      3'b010:  r = olc_nz & ~b;
      3'b011:  r = olc_nz &  b;
      3'b101:  r = ~olc_nz;
      3'b110:  r = olc_nz;
      3'b111:  r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // OR of the selected true/complemented old flag terms.
  function automatic logic flag_mix(input logic [SEL_W-1:0] sel,
                                    input logic a, input logic b, input logic c);
    return |(sel & {~c, c, ~b, b, ~a, a});
  endfunction

endpackage

// File: rtl/dxc_pred.sv
module dxc_pred (
  input  logic [2:0] code,
  input  logic       olc_nz,
  input  logic       a,
  input  logic       b,
  output logic       pass
);
  import dxc_pkg::*;

  always_comb pass = pred_ok(code, olc_nz, a, b);
endmodule

// File: rtl/dxc_counters.sv
module dxc_counters #(
  parameter int OLC_W = 6,
  parameter int ILC_W = 6,
  parameter int IMM_W = 6,
  parameter int DL_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_go,
  input  logic [2:0]       set_op,
  input  logic [IMM_W-1:0] set_imm,
  input  logic [DL_W-1:0]  dl_low,
  input  logic             torp_hit,
  input  logic             ilc_step,
  input  logic             ilc_rearm,
  output logic [OLC_W-1:0] olc_q,
  output logic [ILC_W-1:0] ilc_q,
  output logic             ilc_inf_q,
  output logic             olc_hit_zero
);
  import dxc_pkg::*;

  logic [OLC_W-1:0] olc_d;
  logic [ILC_W-1:0] ilc_d;
  logic             inf_d;

  function automatic logic [OLC_W-1:0] dec_sat(input logic [OLC_W-1:0] v);
    return (v == '0) ? v : v - OLC_W'(1);
  endfunction

  always_comb begin
    olc_d = olc_q;
    if (torp_hit) begin
      olc_d = '0;
    end else if (set_go) begin
      case (setop_e'(set_op))
        S_OLC_IMM: olc_d = OLC_W'(set_imm);
        S_OLC_DL:  olc_d = OLC_W'(dl_low);
        S_OLC_DEC: olc_d = dec_sat(olc_q);
        default:   ;
      endcase
    end
  end

  always_comb begin
    ilc_d = ilc_q;
    inf_d = ilc_inf_q;
    if (ilc_rearm) begin
      ilc_d = ILC_W'(1);
      inf_d = 1'b0;
    end else if (ilc_step) begin
      ilc_d = ilc_q - ILC_W'(1);
    end else if (set_go) begin
      case (setop_e'(set_op))
        S_ILC_IMM: begin ilc_d = ILC_W'(set_imm); inf_d = 1'b0; end
        S_ILC_DL:  begin ilc_d = ILC_W'(dl_low);  inf_d = 1'b0; end
        S_ILC_INF: inf_d = 1'b1;
        default:   ;
      endcase
    end
  end

  assign olc_hit_zero = (olc_q != '0) && (olc_d == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      olc_q     <= '0;
      ilc_q     <= ILC_W'(1);
      ilc_inf_q <= 1'b0;
    end else begin
      olc_q     <= olc_d;
      ilc_q     <= ilc_d;
      ilc_inf_q <= inf_d;
    end
  end
endmodule

// File: rtl/dxc_flags.sv
module dxc_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ab_upd,
  input  logic [5:0] sel_a,
  input  logic [5:0] sel_b,
  input  logic       c_upd,
  input  logic       c_src,
  output logic       a_q,
  output logic       b_q,
  output logic       c_q
);
  import dxc_pkg::*;

  logic a_d, b_d, c_d;

  always_comb begin
    a_d = ab_upd ? flag_mix(sel_a, a_q, b_q, c_q) : a_q;
    b_d = ab_upd ? flag_mix(sel_b, a_q, b_q, c_q) : b_q;
    c_d = c_upd  ? c_src : c_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
      c_q <= c_d;
    end
  end
endmodule

// File: rtl/dock_exec_ctl.sv
module dock_exec_ctl #(
  parameter int OLC_W     = 6,
  parameter int ILC_W     = 6,
  parameter int IMM_W     = 6,
  parameter int DL_W      = 6,
  parameter bit IS_OUTPUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             od_valid,
  input  logic [1:0]       od_kind,
  input  logic [2:0]       od_pred,
  input  logic             od_intr,
  input  logic             mv_ti,
  input  logic             mv_di,
  input  logic             mv_dc,
  input  logic             mv_do,
  input  logic             mv_to,
  input  logic [2:0]       set_op,
  input  logic [IMM_W-1:0] set_imm,
  input  logic [DL_W-1:0]  dl_low,
  input  logic [5:0]       next_a,
  input  logic [5:0]       next_b,
  input  logic             torp_waiting,
  input  logic             tok_pred_full,
  input  logic             dat_pred_full,
  input  logic             dat_succ_empty,
  input  logic             tok_succ_empty,
  input  logic             sig_bit,
  input  logic             ship_c,
  output logic             done,
  output logic             nm_exec,
  output logic             fire,
  output logic             fire_ti,
  output logic             fire_di,
  output logic             fire_dc,
  output logic             fire_do,
  output logic             fire_to,
  output logic             torp_take,
  output logic             olc_hit_zero,
  output logic [OLC_W-1:0] olc_val,
  output logic [ILC_W-1:0] ilc_val,
  output logic             ilc_inf,
  output logic             flag_a,
  output logic             flag_b,
  output logic             flag_c
);
  import dxc_pkg::*;

  // Named internal events, visible to the bound checker.
  logic pass_w;
  logic is_move;
  logic ev_torp;
  logic ev_mv_act;
  logic ev_mv_zero;
  logic mv_ready;
  logic ev_fire;
  logic ev_mv_last;
  logic ev_set;
  logic ev_plain;
  logic ev_ilc_step;
  logic ev_ilc_rearm;
  logic ev_flags;
  logic c_upd;
  logic c_src;

  dxc_pred u_pred (
    .code   (od_pred),
    .olc_nz (olc_val != '0),
    .a      (flag_a),
    .b      (flag_b),
    .pass   (pass_w)
  );

  always_comb begin
    is_move      = (od_kind == K_MOVE);
    ev_torp      = od_valid && pass_w && is_move && od_intr && torp_waiting;
    ev_mv_act    = od_valid && pass_w && is_move && !ev_torp;
    ev_mv_zero   = ev_mv_act && !ilc_inf && (ilc_val == '0);
    mv_ready     = dat_succ_empty && tok_succ_empty &&
                   (!mv_ti || tok_pred_full) && (!mv_di || dat_pred_full);
    ev_fire      = ev_mv_act && !ev_mv_zero && mv_ready;
    ev_mv_last   = ev_fire && !ilc_inf && (ilc_val == ILC_W'(1));
    ev_set       = od_valid && pass_w && (od_kind == K_SET);
    ev_plain     = od_valid && pass_w && !is_move && (od_kind != K_SET);
    ev_ilc_step  = ev_fire && !ilc_inf && (ilc_val > ILC_W'(1));
    ev_ilc_rearm = ev_torp || ev_mv_zero || ev_mv_last;
    ev_flags     = ev_set && (set_op == S_FLAGS);
  end

  assign done      = od_valid && (!pass_w || ev_torp || ev_mv_zero || ev_mv_last ||
                                  ev_set || ev_plain);
  assign nm_exec   = ev_set || ev_plain;
  assign fire      = ev_fire;
  assign fire_ti   = ev_fire && mv_ti;
  assign fire_di   = ev_fire && mv_di;
  assign fire_dc   = ev_fire && mv_dc;
  assign fire_do   = ev_fire && mv_do;
  assign fire_to   = ev_fire && mv_to;
  assign torp_take = ev_torp;

  // Source of the control flag depends on the dock side.
  generate
    if (IS_OUTPUT) begin : g_out_side
      assign c_upd = ev_fire && (mv_di || mv_ti);
      assign c_src = mv_di ? ship_c : sig_bit;
    end else begin : g_in_side
      logic unused_ship;
      assign unused_ship = ship_c;
      assign c_upd = ev_fire && (mv_di || mv_ti);
      assign c_src = sig_bit;
    end
  endgenerate

  dxc_counters #(
    .OLC_W (OLC_W),
    .ILC_W (ILC_W),
    .IMM_W (IMM_W),
    .DL_W  (DL_W)
  ) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_go       (ev_set),
    .set_op       (set_op),
    .set_imm      (set_imm),
    .dl_low       (dl_low),
    .torp_hit     (ev_torp),
    .ilc_step     (ev_ilc_step),
    .ilc_rearm    (ev_ilc_rearm),
    .olc_q        (olc_val),
    .ilc_q        (ilc_val),
    .ilc_inf_q    (ilc_inf),
    .olc_hit_zero (olc_hit_zero)
  );

  dxc_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .ab_upd (ev_flags),
    .sel_a  (next_a),
    .sel_b  (next_b),
    .c_upd  (c_upd),
    .c_src  (c_src),
    .a_q    (flag_a),
    .b_q    (flag_b),
    .c_q    (flag_c)
  );
endmodule

// File: rtl/dxc_checker.sv
module dxc_checker #(
  parameter int OLC_W = 6,
  parameter int ILC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             od_valid,
  input logic [2:0]       od_pred,
  input logic [2:0]       set_op,
  input logic             pass_w,
  input logic             ev_set,
  input logic             done,
  input logic             nm_exec,
  input logic             fire,
  input logic             fire_ti,
  input logic             fire_di,
  input logic             torp_take,
  input logic             olc_hit_zero,
  input logic             dat_succ_empty,
  input logic             tok_succ_empty,
  input logic             tok_pred_full,
  input logic             dat_pred_full,
  input logic [OLC_W-1:0] olc_val,
  input logic [ILC_W-1:0] ilc_val,
  input logic             ilc_inf,
  input logic             flag_c
);

  p_unused_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    od_valid && (od_pred == 3'b100) |-> !fire && !nm_exec);

  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    od_valid && !pass_w |-> done && !fire && !nm_exec && !torp_take);

  p_torp_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    torp_take |=> (olc_val == '0) && (ilc_val == ILC_W'(1)) && !ilc_inf);

  p_torp_no_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    torp_take |-> !fire && done);

  p_move_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && done |=> (ilc_val == ILC_W'(1)) && !ilc_inf);

  p_inf_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ilc_inf |-> !done);

  p_fire_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> dat_succ_empty && tok_succ_empty &&
             (!fire_ti || tok_pred_full) && (!fire_di || dat_pred_full));

  p_c_only_on_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> flag_c == $past(flag_c));

  p_dec_saturates_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set && (set_op == 3'd2) && (olc_val == '0) |=> olc_val == '0);

  p_hit_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    olc_hit_zero |=> olc_val == '0);

endmodule

bind dock_exec_ctl dxc_checker #(.OLC_W(OLC_W), .ILC_W(ILC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .od_valid       (od_valid),
  .od_pred        (od_pred),
  .set_op         (set_op),
  .pass_w         (pass_w),
  .ev_set         (ev_set),
  .done           (done),
  .nm_exec        (nm_exec),
  .fire           (fire),
  .fire_ti        (fire_ti),
  .fire_di        (fire_di),
  .torp_take      (torp_take),
  .olc_hit_zero   (olc_hit_zero),
  .dat_succ_empty (dat_succ_empty),
  .tok_succ_empty (tok_succ_empty),
  .tok_pred_full  (tok_pred_full),
  .dat_pred_full  (dat_pred_full),
  .olc_val        (olc_val),
  .ilc_val        (ilc_val),
  .ilc_inf        (ilc_inf),
  .flag_c         (flag_c)
);

// File: tb/tb_dock_exec_ctl.sv
`timescale 1ns/1ps
module tb_dock_exec_ctl;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic od_valid = 0, od_intr = 0;
  logic [1:0] od_kind = 0;
  logic [2:0] od_pred = 0, set_op = 0;
  logic mv_ti = 0, mv_di = 0, mv_dc = 0, mv_do = 0, mv_to = 0;
  logic [5:0] set_imm = 0, dl_low = 0, next_a = 0, next_b = 0;
  logic torp_waiting = 0, tok_pred_full = 1, dat_pred_full = 1;
  logic dat_succ_empty = 1, tok_succ_empty = 1, sig_bit = 0, ship_c = 0;

  logic done, nm_exec, fire, fire_ti, fire_di, fire_dc, fire_do, fire_to;
  logic torp_take, olc_hit_zero, ilc_inf, flag_a, flag_b, flag_c;
  logic [5:0] olc_val, ilc_val;

  logic o_done, o_nm, o_fire, o_fti, o_fdi, o_fdc, o_fdo, o_fto;
  logic o_torp, o_hz, o_inf, o_a, o_b, o_c;
  logic [5:0] o_olc, o_ilc;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  dock_exec_ctl dut (
    .clk(clk), .rst_n(rst_n), .od_valid(od_valid), .od_kind(od_kind), .od_pred(od_pred),
    .od_intr(od_intr), .mv_ti(mv_ti), .mv_di(mv_di), .mv_dc(mv_dc), .mv_do(mv_do),
    .mv_to(mv_to), .set_op(set_op), .set_imm(set_imm), .dl_low(dl_low), .next_a(next_a),
    .next_b(next_b), .torp_waiting(torp_waiting), .tok_pred_full(tok_pred_full),
    .dat_pred_full(dat_pred_full), .dat_succ_empty(dat_succ_empty),
    .tok_succ_empty(tok_succ_empty), .sig_bit(sig_bit), .ship_c(ship_c),
    .done(done), .nm_exec(nm_exec), .fire(fire), .fire_ti(fire_ti), .fire_di(fire_di),
    .fire_dc(fire_dc), .fire_do(fire_do), .fire_to(fire_to), .torp_take(torp_take),
    .olc_hit_zero(olc_hit_zero), .olc_val(olc_val), .ilc_val(ilc_val), .ilc_inf(ilc_inf),
    .flag_a(flag_a), .flag_b(flag_b), .flag_c(flag_c)
  );

  dock_exec_ctl #(.IS_OUTPUT(1'b1)) dut_o (
    .clk(clk), .rst_n(rst_n), .od_valid(od_valid), .od_kind(od_kind), .od_pred(od_pred),
    .od_intr(od_intr), .mv_ti(mv_ti), .mv_di(mv_di), .mv_dc(mv_dc), .mv_do(mv_do),
    .mv_to(mv_to), .set_op(set_op), .set_imm(set_imm), .dl_low(dl_low), .next_a(next_a),
    .next_b(next_b), .torp_waiting(torp_waiting), .tok_pred_full(tok_pred_full),
    .dat_pred_full(dat_pred_full), .dat_succ_empty(dat_succ_empty),
    .tok_succ_empty(tok_succ_empty), .sig_bit(sig_bit), .ship_c(ship_c),
    .done(o_done), .nm_exec(o_nm), .fire(o_fire), .fire_ti(o_fti), .fire_di(o_fdi),
    .fire_dc(o_fdc), .fire_do(o_fdo), .fire_to(o_fto), .torp_take(o_torp),
    .olc_hit_zero(o_hz), .olc_val(o_olc), .ilc_val(o_ilc), .ilc_inf(o_inf),
    .flag_a(o_a), .flag_b(o_b), .flag_c(o_c)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One set instruction with an always-true predicate; returns at a negedge.
  task automatic do_set(input logic [2:0] op, input logic [5:0] imm,
                        input logic [5:0] na, input logic [5:0] nb);
    @(negedge clk);
    od_valid = 1; od_kind = 2'd1; od_pred = 3'b111;
    set_op = op; set_imm = imm; next_a = na; next_b = nb;
    @(negedge clk);
    od_valid = 0;
  endtask

  task automatic move_on(input logic [2:0] pred, input logic intr,
                         input logic ti, input logic di, input logic dout);
    @(negedge clk);
    od_valid = 1; od_kind = 2'd0; od_pred = pred; od_intr = intr;
    mv_ti = ti; mv_di = di; mv_dc = 0; mv_do = dout; mv_to = 0;
  endtask

  // Hold the on-deck move until done; count fires.
  task automatic run_move(input int maxc, output int nf, output bit fin);
    nf = 0; fin = 0;
    for (int i = 0; i < maxc; i++) begin
      #2;
      if (fire) nf++;
      if (done) fin = 1;
      @(negedge clk);
      if (fin) break;
    end
    od_valid = 0;
  endtask

  // Predicate vectors: {code[2:0], olc_nonzero, A, B, expected execute}
  localparam logic [6:0] PVEC [16] = '{
    7'b000_1_0_0_1, 7'b000_1_1_0_0, 7'b000_0_0_0_0, 7'b001_1_1_0_1,
    7'b001_1_0_0_0, 7'b010_1_0_0_1, 7'b010_1_0_1_0, 7'b011_1_0_1_1,
    7'b011_0_0_1_0, 7'b100_1_0_0_0, 7'b100_0_0_0_0, 7'b101_0_0_0_1,
    7'b101_1_0_0_0, 7'b110_1_1_1_1, 7'b110_0_0_0_0, 7'b111_0_1_1_1
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int nf;
    bit fin;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #2;
    // R12 reset state
    check("R12 olc", olc_val, 0);
    check("R12 ilc", ilc_val, 1);
    check("R12 inf", ilc_inf, 0);
    check("R12 flags", {flag_a, flag_b, flag_c}, 0);
    check("R12 strobes", {done, fire, nm_exec, torp_take}, 0);

    // R1 / R2 predicate table
    for (int i = 0; i < 16; i++) begin
      logic [6:0] v;
      v = PVEC[i];
      do_set(3'd6, 6'd0, v[2] ? 6'b000011 : 6'b0, v[1] ? 6'b000011 : 6'b0);
      do_set(3'd0, v[3] ? 6'd5 : 6'd0, 6'd0, 6'd0);
      @(negedge clk);
      od_valid = 1; od_kind = 2'd3; od_pred = v[6:4];
      #2;
      check($sformatf("R1 pred vec %0d exec", i), nm_exec, v[0]);
      check($sformatf("R2 pred vec %0d done", i), done, 1);
      @(negedge clk);
      od_valid = 0;
    end

    // R9 / R10 set operations
    dl_low = 6'd42;
    do_set(3'd0, 6'd9, 0, 0);  check("R9 olc imm", olc_val, 9);
    do_set(3'd1, 6'd0, 0, 0);  check("R9 olc latch", olc_val, 42);
    do_set(3'd2, 6'd0, 0, 0);  check("R9 olc dec", olc_val, 41);
    do_set(3'd4, 6'd0, 0, 0);  check("R10 ilc latch", ilc_val, 42);
    do_set(3'd5, 6'd0, 0, 0);  check("R10 ilc inf", ilc_inf, 1);
    do_set(3'd3, 6'd3, 0, 0);
    check("R10 ilc imm", {ilc_inf, ilc_val}, {1'b0, 6'd3});
    do_set(3'd7, 6'd20, 0, 0);
    check("R9 no-op olc", olc_val, 41);
    check("R10 no-op ilc", ilc_val, 3);

    // R4 finite repetition
    move_on(3'b111, 0, 0, 0, 1);
    run_move(10, nf, fin);
    check("R4 fires for ilc=3", nf, 3);
    check("R4 retired", fin, 1);
    check("R4 ilc back to one", ilc_val, 1);
    do_set(3'd3, 6'd0, 0, 0);
    move_on(3'b111, 0, 0, 0, 1);
    run_move(10, nf, fin);
    check("R4 ilc=0 fires", nf, 0);
    check("R4 ilc=0 retired", fin, 1);
    check("R4 ilc=0 rearmed", ilc_val, 1);
    do_set(3'd3, 6'd5, 0, 0);
    move_on(3'b101, 0, 0, 0, 1);
    #2;
    check("R2 failed move no fire", {fire, done}, 2'b01);
    @(negedge clk); od_valid = 0;
    check("R2 failed move keeps ilc", ilc_val, 5);
    do_set(3'd3, 6'd1, 0, 0);

    // R6 readiness gating
    dat_succ_empty = 0;
    move_on(3'b111, 0, 0, 0, 1);
    #2; check("R6 full successor blocks", {fire, done}, 0);
    @(negedge clk); #2; check("R6 still blocked", {fire, done}, 0);
    @(negedge clk); dat_succ_empty = 1;
    #2; check("R6 fires when empty", {fire, fire_do, done}, 3'b111);
    @(negedge clk); od_valid = 0;
    tok_pred_full = 0;
    move_on(3'b111, 0, 1, 0, 0);
    #2; check("R6 token source empty blocks", fire, 0);
    @(negedge clk); tok_pred_full = 1;
    #2; check("R6 strobes mirror bits", {fire, fire_ti, fire_di, fire_do}, 4'b1100);
    @(negedge clk); od_valid = 0;

    // R3 cases where no torpedo is taken
    torp_waiting = 1;
    move_on(3'b111, 0, 0, 0, 1);
    #2; check("R3 non-interruptible fires", {fire, torp_take}, 2'b10);
    @(negedge clk); od_valid = 0;
    @(negedge clk);
    od_valid = 1; od_kind = 2'd3; od_pred = 3'b111; od_intr = 1;
    #2; check("R3 non-move ignores torpedo", {nm_exec, torp_take}, 2'b10);
    @(negedge clk); od_valid = 0;
    move_on(3'b101, 1, 0, 0, 1);
    #2; check("R3 failed predicate keeps torpedo", {torp_take, done}, 2'b01);
    @(negedge clk); od_valid = 0; torp_waiting = 0;

    // R5 infinite repetition ended by torpedo
    do_set(3'd5, 6'd0, 0, 0);
    move_on(3'b111, 1, 0, 0, 1);
    for (int k = 0; k < 5; k++) begin
      #2; check("R5 infinite fires, no done", {fire, done}, 2'b10);
      @(negedge clk);
    end
    torp_waiting = 1;
    #2;
    check("R3 torpedo taken", {torp_take, done, fire}, 3'b110);
    check("R11 hit-zero on torpedo", olc_hit_zero, 1);
    @(negedge clk); od_valid = 0; torp_waiting = 0;
    check("R3 olc cleared", olc_val, 0);
    check("R3 ilc one", {ilc_inf, ilc_val}, {1'b0, 6'd1});

    // R11 saturating decrement
    do_set(3'd0, 6'd1, 0, 0);
    @(negedge clk);
    od_valid = 1; od_kind = 2'd1; od_pred = 3'b111; set_op = 3'd2;
    #2; check("R11 pulse on 1->0", olc_hit_zero, 1);
    @(negedge clk); od_valid = 0;
    check("R11 reaches zero", olc_val, 0);
    @(negedge clk);
    od_valid = 1;
    #2; check("R11 no pulse at zero", olc_hit_zero, 0);
    @(negedge clk); od_valid = 0;
    check("R11 stays zero", olc_val, 0);

    // R7 control flag source, both dock sides
    sig_bit = 1; ship_c = 0;
    move_on(3'b111, 0, 0, 1, 0); run_move(4, nf, fin);
    check("R7 in-dock di takes signal", flag_c, 1);
    check("R7 out-dock di takes ship", o_c, 0);
    sig_bit = 0; ship_c = 1;
    move_on(3'b111, 0, 1, 0, 0); run_move(4, nf, fin);
    check("R7 ti takes signal both sides", {flag_c, o_c}, 2'b00);
    sig_bit = 1;
    move_on(3'b111, 0, 1, 0, 0); run_move(4, nf, fin);
    check("R7 ti signal=1", {flag_c, o_c}, 2'b11);
    sig_bit = 0; ship_c = 0;
    move_on(3'b111, 0, 0, 0, 1); run_move(4, nf, fin);
    check("R7 no input keeps C", {flag_c, o_c}, 2'b11);

    // R8 flag mixing (bit0 A, bit1 ~A, bit2 B, bit3 ~B, bit4 C, bit5 ~C)
    do_set(3'd6, 6'd0, 6'b000000, 6'b000011);
    check("R8 setup", {flag_a, flag_b, flag_c}, 3'b011);
    do_set(3'd6, 6'd0, 6'b010000, 6'b001000);
    check("R8 A<=C, B<=~B", {flag_a, flag_b, flag_c}, 3'b101);
    do_set(3'd6, 6'd0, 6'b100010, 6'b000001);
    check("R8 A<=~C|~A, B<=A", {flag_a, flag_b, flag_c}, 3'b011);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule